// File: doc/BRIEF.md
# LFSR Divider Code Decoder

This block converts an encoded clock-divider setting into the plain integer it stands for. Divider settings of this kind are not held in binary. Each value is a state of a small shift register with linear feedback. To recover the integer, the block replays that shift-register sequence from a fixed seed and counts down from the family ceiling until the state equals the stored code. Three code families are supported: an input pre-divider, an output post-divider and a feedback multiplier. Each family has its own code width, register width, feedback taps, seed, ceiling and three reserved codes that stand for 0, 1 and 2.

A caller drives a family selector and a code, then pulses `start` for one cycle. Reserved codes, and the unused selector value, finish on the next clock. Any other code starts a search that takes one register step per clock, with `busy` high while the search runs. The end of every decode is marked by a one-cycle `done` pulse. At that point `value` holds the integer, or all ones together with `not_found` when no state in the window matched. The result stays on the outputs until the next decode finishes.

Top module: `divcode_decoder`

## Requirements
- R1: After reset, `busy`, `done` and `not_found` are low and `value` is 0.
- R2: Family select encoding: 0 = pre-divider (10-bit code), 1 = post-divider (7-bit code), 2 = feedback multiplier (17-bit code). The reserved codes are 0x202→2, 0x302→1 and 0x3FF→0 for the pre-divider; 0x42→2, 0x62→1 and 0x7F→0 for the post-divider; 0x10003→2, 0x18003→1 and 0x1FFFF→0 for the multiplier. A reserved code gives `done` on the first rising edge after the one that samples `start`, with `not_found` low, and `busy` never goes high.
- R3: Code bits at or above the selected family's code width have no effect on the result.
- R4: Pre-divider search: an 8-bit register is seeded with 0x80. Each step shifts it right by one and loads bit 7 with the XOR of old bits 0, 2, 3 and 4. The candidate starts at 256 and falls by one per step. The result is the candidate at the first step whose new state equals the code. A match at candidate k raises `done` on rising edge 256−k+2, counting the edge that samples `start` as edge 1.
- R5: Post-divider search: a 5-bit register is seeded with 0x10, bit 4 is loaded with old bit 0 XOR old bit 2, and the candidate starts at 32. The matching and timing rules are the same as in R4, with 32 in place of 256.
- R6: Multiplier search: a 15-bit register is seeded with 0x4000, bit 14 is loaded with old bit 0 XOR old bit 1, and the candidate starts at 32768. The matching and timing rules are the same as in R4, with 32768 in place of 256.
- R7: If no state matches by the compare at candidate 3, `value` is 0xFFFF and `not_found` is high. This applies to codes with bits set above the register width, such as pre-divider 0x100. The miss raises `done` on edge max−1.
- R8: Family select 3 gives `value` 0xFFFF with `not_found` high on the first edge after `start`, without any search.
- R9: `done` is high for exactly one cycle per decode. `busy` is high on every cycle of a search and low while `done` is high.
- R10: A `start` pulse while `busy` is high is ignored. The running search ends with the result and timing of the code that started it.
- R11: `value` and `not_found` change only in a cycle where `done` is high. They hold while the inputs change without an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to decode, sampled when idle |
| mode | input | 2 | Family select (0 pre, 1 post, 2 multiplier, 3 unused) |
| code | input | 17 | Encoded divider setting, low bits used per family |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| value | output | 16 | Decoded integer, or all ones on a miss |
| not_found | output | 1 | No register state matched the code |

## Verification
The hardest case to reach from the ports is a `start` pulse that arrives in the middle of a long search, because the block only accepts requests when idle. The bench therefore counts cycles after a search has begun and drives a second request with a reserved code partway through. It then checks that both the result and the completion edge belong to the first code. The edges of the search window are reached by stepping a bench-side copy of each register sequence to build codes that match on the very first step or near candidate 3. Codes with bits above the register width force a full-length miss, including the 32766-step multiplier miss.

// File: rtl/divcode_pkg.sv
package divcode_pkg;
   typedef enum logic [1:0] {
      FAM_PRE  = 2'd0,
      FAM_POST = 2'd1,
      FAM_FB   = 2'd2,
      FAM_RSVD = 2'd3
   } fam_e;
endpackage

// File: rtl/divcode_step.sv
module divcode_step #(
   parameter int         W    = 8,
   parameter logic [W-1:0] TAPS = '0
) (
   input  logic [W-1:0] cur,
   output logic [W-1:0] nxt
);
   if (W < 2) begin : g_bad_w
      $error("divcode_step: register width must be at least 2");
   end

   always_comb begin
      nxt        = cur >> 1;
      nxt[W-1]   = ^(cur & TAPS);
   end
endmodule

// File: rtl/divcode_special.sv
module divcode_special
   import divcode_pkg::*;
#(
   parameter int CW     = 17,
   parameter int N_CW   = 10,
   parameter int P_CW   = 7,
   parameter int M_CW   = 17,
   parameter int N_ZERO = 'h3FF,
   parameter int N_ONE  = 'h302,
   parameter int N_TWO  = 'h202,
   parameter int P_ZERO = 'h7F,
   parameter int P_ONE  = 'h62,
   parameter int P_TWO  = 'h42,
   parameter int M_ZERO = 'h1FFFF,
   parameter int M_ONE  = 'h18003,
   parameter int M_TWO  = 'h10003
) (
   input  fam_e          fam,
   input  logic [CW-1:0] code,
   output logic          hit,
   output logic [1:0]    sval
);
   if (N_CW > CW || P_CW > CW || M_CW > CW) begin : g_bad_cw
      $error("divcode_special: family code wider than code port");
   end

   logic [N_CW-1:0] c_n;
   logic [P_CW-1:0] c_p;
   logic [M_CW-1:0] c_m;

   assign c_n = code[N_CW-1:0];
   assign c_p = code[P_CW-1:0];
   assign c_m = code[M_CW-1:0];

   always_comb begin
      hit  = 1'b0;
      sval = 2'd0;
      unique case (fam)
         FAM_PRE: begin
            if (c_n == N_CW'(N_ZERO))     begin hit = 1'b1; sval = 2'd0; end
            else if (c_n == N_CW'(N_ONE)) begin hit = 1'b1; sval = 2'd1; end
            else if (c_n == N_CW'(N_TWO)) begin hit = 1'b1; sval = 2'd2; end
         end
         FAM_POST: begin
            if (c_p == P_CW'(P_ZERO))     begin hit = 1'b1; sval = 2'd0; end
            else if (c_p == P_CW'(P_ONE)) begin hit = 1'b1; sval = 2'd1; end
            else if (c_p == P_CW'(P_TWO)) begin hit = 1'b1; sval = 2'd2; end
         end
         FAM_FB: begin
            if (c_m == M_CW'(M_ZERO))     begin hit = 1'b1; sval = 2'd0; end
            else if (c_m == M_CW'(M_ONE)) begin hit = 1'b1; sval = 2'd1; end
            else if (c_m == M_CW'(M_TWO)) begin hit = 1'b1; sval = 2'd2; end
         end
         default: begin
            hit  = 1'b0;
            sval = 2'd0;
         end
      endcase
   end
endmodule

// File: rtl/divcode_decoder.sv
module divcode_decoder
   import divcode_pkg::*;
#(
   parameter int N_CW   = 10,
   parameter int P_CW   = 7,
   parameter int M_CW   = 17,
   parameter int N_LW   = 8,
   parameter int P_LW   = 5,
   parameter int M_LW   = 15,
   parameter int N_SEED = 'h80,
   parameter int P_SEED = 'h10,
   parameter int M_SEED = 'h4000,
   parameter int N_TAPS = 'h1D,
   parameter int P_TAPS = 'h05,
   parameter int M_TAPS = 'h0003,
   parameter int N_MAX  = 256,
   parameter int P_MAX  = 32,
   parameter int M_MAX  = 32768,
   parameter int LAST   = 3,
   localparam int CW    = (N_CW > P_CW) ? ((N_CW > M_CW) ? N_CW : M_CW)
                                        : ((P_CW > M_CW) ? P_CW : M_CW),
   localparam int LW    = (N_LW > P_LW) ? ((N_LW > M_LW) ? N_LW : M_LW)
                                        : ((P_LW > M_LW) ? P_LW : M_LW),
   localparam int MAXC  = (N_MAX > P_MAX) ? ((N_MAX > M_MAX) ? N_MAX : M_MAX)
                                          : ((P_MAX > M_MAX) ? P_MAX : M_MAX),
   localparam int VW    = $clog2(MAXC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    mode,
   input  logic [CW-1:0] code,
   output logic          busy,
   output logic          done,
   output logic [VW-1:0] value,
   output logic          not_found
);
   if (N_LW > N_CW || P_LW > P_CW || M_LW > M_CW) begin : g_bad_lw
      $error("divcode_decoder: register wider than its code");
   end
   if (LAST < 1 || LAST > P_MAX || LAST > N_MAX || LAST > M_MAX) begin : g_bad_last
      $error("divcode_decoder: final candidate outside the window");
   end

   typedef enum logic {ST_IDLE = 1'b0, ST_SEARCH = 1'b1} st_e;

   st_e            st_q;
   fam_e           fam_in, fam_q;
   logic [CW-1:0]  code_q, mask_in;
   logic [LW-1:0]  lfsr_q, seed_in, nxt_sel;
   logic [VW-1:0]  cnt_q, max_in;
   logic [VW-1:0]  val_q;
   logic           nf_q, done_q;
   logic           sp_hit, match;
   logic [1:0]     sp_val;
   logic [N_LW-1:0] n_nxt;
   logic [P_LW-1:0] p_nxt;
   logic [M_LW-1:0] m_nxt;

   assign fam_in = fam_e'(mode);

   divcode_special #(
      .CW(CW), .N_CW(N_CW), .P_CW(P_CW), .M_CW(M_CW)
   ) u_special (
      .fam (fam_in),
      .code(code),
      .hit (sp_hit),
      .sval(sp_val)
   );

   divcode_step #(.W(N_LW), .TAPS(N_LW'(N_TAPS))) u_step_n (
      .cur(lfsr_q[N_LW-1:0]), .nxt(n_nxt));
   divcode_step #(.W(P_LW), .TAPS(P_LW'(P_TAPS))) u_step_p (
      .cur(lfsr_q[P_LW-1:0]), .nxt(p_nxt));
   divcode_step #(.W(M_LW), .TAPS(M_LW'(M_TAPS))) u_step_m (
      .cur(lfsr_q[M_LW-1:0]), .nxt(m_nxt));

   always_comb begin
      mask_in = '0;
      seed_in = '0;
      max_in  = '0;
      unique case (fam_in)
         FAM_PRE:  begin mask_in = CW'((64'd1 << N_CW) - 1); seed_in = LW'(N_SEED); max_in = VW'(N_MAX); end
         FAM_POST: begin mask_in = CW'((64'd1 << P_CW) - 1); seed_in = LW'(P_SEED); max_in = VW'(P_MAX); end
         FAM_FB:   begin mask_in = CW'((64'd1 << M_CW) - 1); seed_in = LW'(M_SEED); max_in = VW'(M_MAX); end
         default:  begin mask_in = '0; seed_in = '0; max_in = '0; end
      endcase
   end

   always_comb begin
      unique case (fam_q)
         FAM_PRE:  nxt_sel = LW'(n_nxt);
         FAM_POST: nxt_sel = LW'(p_nxt);
         FAM_FB:   nxt_sel = LW'(m_nxt);
         default:  nxt_sel = '0;
      endcase
   end

   assign match = (CW'(nxt_sel) == code_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fam_q  <= FAM_PRE;
         code_q <= '0;
         lfsr_q <= '0;
         cnt_q  <= '0;
         val_q  <= '0;
         nf_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  fam_q  <= fam_in;
                  code_q <= code & mask_in;
                  if (fam_in == FAM_RSVD) begin
                     val_q  <= '1;
                     nf_q   <= 1'b1;
                     done_q <= 1'b1;
                  end else if (sp_hit) begin
                     val_q  <= VW'(sp_val);
                     nf_q   <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     lfsr_q <= seed_in;
                     cnt_q  <= max_in;
                     st_q   <= ST_SEARCH;
                  end
               end
            end
            ST_SEARCH: begin
               if (match) begin
                  val_q  <= cnt_q;
                  nf_q   <= 1'b0;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else if (cnt_q == VW'(LAST)) begin
                  val_q  <= '1;
                  nf_q   <= 1'b1;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else begin
                  lfsr_q <= nxt_sel;
                  cnt_q  <= cnt_q - 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st_q == ST_SEARCH);
   assign done      = done_q;
   assign value     = val_q;
   assign not_found = nf_q;

   // R9
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(code_q) && $stable(fam_q)));

   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || cnt_q == $past(cnt_q) - 1'b1));

   // R7
   count_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> cnt_q >= VW'(LAST));

   // R11
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(value) && $stable(not_found)) |-> done);

   // R8
   rsvd_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fam_q == FAM_RSVD) |-> (not_found && value == '1));
endmodule

// File: tb/divcode_decoder_test.sv
module divcode_decoder_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [16:0] code = '0;
   logic        busy, done, not_found;
   logic [15:0] value;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_P/2) clk = ~clk;

   divcode_decoder uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .code(code),
      .busy(busy), .done(done), .value(value), .not_found(not_found)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int stepf(input int fam, input int x);
      case (fam)
         0: return (((x ^ (x >> 2) ^ (x >> 3) ^ (x >> 4)) & 1) << 7) | ((x >> 1) & 'h7F);
         1: return (((x ^ (x >> 2)) & 1) << 4) | ((x >> 1) & 'hF);
         default: return (((x ^ (x >> 1)) & 1) << 14) | ((x >> 1) & 'h3FFF);
      endcase
   endfunction

   function automatic int gen_code(input int fam, input int k);
      int x = (fam == 0) ? 'h80 : (fam == 1) ? 'h10 : 'h4000;
      for (int i = 0; i < k; i++) x = stepf(fam, x);
      return x;
   endfunction

   function automatic void model(input int fam, input int raw, output int val,
                                 output bit nf, output int lat);
      int c, x, mx, steps;
      val = 'hFFFF; nf = 1'b1; lat = 1;
      if (fam == 3) return;
      c  = raw & ((fam == 0) ? 'h3FF : (fam == 1) ? 'h7F : 'h1FFFF);
      if ((fam == 0 && c == 'h3FF) || (fam == 1 && c == 'h7F) || (fam == 2 && c == 'h1FFFF)) begin val = 0; nf = 0; return; end
      if ((fam == 0 && c == 'h302) || (fam == 1 && c == 'h62) || (fam == 2 && c == 'h18003)) begin val = 1; nf = 0; return; end
      if ((fam == 0 && c == 'h202) || (fam == 1 && c == 'h42) || (fam == 2 && c == 'h10003)) begin val = 2; nf = 0; return; end
      x  = (fam == 0) ? 'h80 : (fam == 1) ? 'h10 : 'h4000;
      mx = (fam == 0) ? 256 : (fam == 1) ? 32 : 32768;
      steps = 0;
      for (int i = mx; i >= 3; i--) begin
         x = stepf(fam, x);
         steps++;
         if (x == c) begin val = i; nf = 0; break; end
      end
      lat = 1 + steps;
   endfunction

   // Runs one decode; inj_at > 0 drives a second start at that cycle count.
   task automatic run(input int fam, input int raw, input string req,
                      input int inj_at = 0, input int inj_code = 'h302);
      int ev, el, lat, busy_bad;
      bit en;
      model(fam, raw, ev, en, el);
      @(negedge clk);
      mode = fam[1:0]; code = raw[16:0]; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 1; busy_bad = 0;
      while (!done && lat < 40000) begin
         if (!busy) busy_bad++;
         if (lat == inj_at) begin mode = 2'd0; code = inj_code[16:0]; start = 1'b1; end
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         lat++;
      end
      chk(done == 1'b1, req, "done seen", done, 1);
      chk(lat == el, req, "latency", lat, el);
      chk(value == ev[15:0], req, "value", value, ev[15:0]);
      chk(not_found == en, req, "not_found", not_found, en);
      // R9: busy through the search, low with done, done one cycle
      chk(busy_bad == 0 && !busy, "R9", "busy pattern", busy_bad, 0);
      @(negedge clk);
      chk(done == 1'b0, "R9", "done width", done, 0);
   endtask

   task automatic t_reset();
      // R1
      chk(!busy && !done && !not_found, "R1", "flags after reset", {busy, done, not_found}, 0);
      chk(value == 16'd0, "R1", "value after reset", value, 0);
   endtask

   task automatic t_special();
      // R2
      int codes[9] = '{'h3FF, 'h302, 'h202, 'h7F, 'h62, 'h42, 'h1FFFF, 'h18003, 'h10003};
      for (int i = 0; i < 9; i++) run(i / 3, codes[i], "R2");
   endtask

   task automatic t_upper_bits();
      // R3
      run(0, 'h10302, "R3");
      run(1, gen_code(1, 7) | 'h1_0400, "R3");
      run(0, gen_code(0, 20) | 'h1F000, "R3");
   endtask

   task automatic t_search_pre();
      // R4
      run(0, gen_code(0, 1), "R4");
      run(0, gen_code(0, 5), "R4");
      run(0, gen_code(0, 100), "R4");
      run(0, gen_code(0, 254), "R4");
   endtask

   task automatic t_search_post();
      // R5
      run(1, gen_code(1, 1), "R5");
      run(1, gen_code(1, 12), "R5");
      run(1, gen_code(1, 30), "R5");
   endtask

   task automatic t_search_fb();
      // R6
      run(2, gen_code(2, 1), "R6");
      run(2, gen_code(2, 777), "R6");
   endtask

   task automatic t_miss();
      // R7
      run(0, 'h100, "R7");
      run(1, 'h00, "R7");
      run(2, 'h08000, "R7");
   endtask

   task automatic t_reserved();
      // R8
      run(3, 'h00123, "R8");
   endtask

   task automatic t_start_ignored();
      // R10
      run(0, gen_code(0, 60), "R10", 4, 'h302);
      run(1, gen_code(1, 20), "R10", 2, 'h7F);
   endtask

   task automatic t_hold();
      // R11
      logic [15:0] v0;
      logic        n0;
      run(1, gen_code(1, 9), "R11");
      v0 = value; n0 = not_found;
      for (int i = 0; i < 4; i++) begin
         mode = 2'(i); code = 17'h1FFFF - 17'(i);
         @(negedge clk);
      end
      chk(value == v0, "R11", "value held", value, v0);
      chk(not_found == n0 && !done, "R11", "flags held", {not_found, done}, {n0, 1'b0});
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_special();
      t_upper_bits();
      t_search_pre();
      t_search_post();
      t_search_fb();
      t_miss();
      t_reserved();
      t_start_ignored();
      t_hold();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule